// File: doc/BRIEF.md
# Burst Bus Initiator

This block is the master side of a 32-bit shared parallel bus on which address and data use the same wires. A local client starts a transaction with a single-cycle start pulse. The pulse carries a 4-bit command code, a start address and a beat count of at least one. The block asserts its bus request and waits for a grant and for the bus to go quiet. It then drives one address phase followed by one or more data phases. Each data phase carries its own byte-enable pattern.

Write data and byte enables come from the client, indexed by the running beat count that the block exports. Read data returns on a one-cycle valid strobe. When the transaction ends, a done pulse reports the outcome and the final beat count. There are four outcomes: normal completion, target stop, target abort, and master abort after a device-select timeout.

All bus control pins are active low. Each driven group has its own output-enable, so the pins can be merged onto a shared wired bus outside the block.

Top module: `burst_initiator`

## Requirements
- R1: While reset is held and directly after it, `req_n`, `frame_n` and `irdy_n` are 1, and `ctl_oe`, `ad_oe`, `cbe_oe`, `par_oe`, `busy` and `done` are 0.
- R2: After a start, `req_n` goes low. No address phase begins until `gnt_n` is low and both `bus_frame_n` and `bus_irdy_n` are high at the same clock edge.
- R3: The address phase lasts one clock. In it `frame_n` goes low, `ad_out` carries the address, `cbe_out` carries the command, and `ad_oe` is 1.
- R4: A command with bit 0 equal to 0 is a read; 0000, 0010, 0110 and 1010 are reads. For a read, the clock after the address phase is a turnaround: `ad_oe` is 0 and `irdy_n` is 1. `ad_oe` stays 0 through the data phases. For a write, `ad_out` carries the write word of the current beat in every data phase.
- R5: A beat completes only on a clock edge at which `irdy_n`, `trdy_n` and `devsel_n` are all low. While the target holds `trdy_n` high, the block keeps `irdy_n` low and waits.
- R6: `frame_n` is high during the final data phase and low in the earlier ones. After the final beat, `irdy_n` returns high on the next clock. `done` then pulses with `result` = 0 and `beat_cnt` equal to the requested count.
- R7: `cbe_out` carries the client byte-enable word for the current beat in every data phase, and a value of 0000 is legal.
- R8: If `devsel_n` is sampled high at each of the first DSEL_CLKS edges after the address phase, the transaction ends with `result` = 3 (master abort). A `devsel_n` first low at the DSEL_CLKS-th edge is still accepted.
- R9: If `stop_n` is low while `devsel_n` is low, the transaction ends with `result` = 1 (target stop). A beat whose `trdy_n` is low in that same clock still counts.
- R10: If `stop_n` is low while `devsel_n` is high, the transaction ends with `result` = 2 (target abort), and no further beat is counted.
- R11: `par_oe` equals the previous clock's `ad_oe`. When `par_oe` is 1, `par_out` is the even parity of the previous clock's `ad_out` and `cbe_out`.
- R12: `frame_n` only rises in a clock in which `irdy_n` is low. When the transaction ends while `frame_n` is still low, the block first drives one clock with `frame_n` high and `irdy_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| cmd | input | 4 | Command code for the address phase |
| addr | input | 32 | Start address |
| beats | input | 4 | Number of data phases (at least 1) |
| wdata | input | 32 | Write word for beat `beat_cnt` |
| be | input | 4 | Active-high byte enables for beat `beat_cnt` |
| busy | output | 1 | Transaction in progress |
| beat_cnt | output | 4 | Beats completed so far / final count |
| rd_valid | output | 1 | Read word valid strobe |
| rd_data | output | 32 | Read word |
| done | output | 1 | One-cycle end-of-transaction pulse |
| result | output | 2 | 0 ok, 1 target stop, 2 target abort, 3 master abort |
| req_n | output | 1 | Bus request |
| gnt_n | input | 1 | Bus grant |
| bus_frame_n | input | 1 | Resolved frame line seen on the bus |
| bus_irdy_n | input | 1 | Resolved initiator-ready line seen on the bus |
| frame_n | output | 1 | Frame drive value |
| irdy_n | output | 1 | Initiator-ready drive value |
| ctl_oe | output | 1 | Enable for frame and initiator-ready |
| ad_out | output | 32 | Address/data drive value |
| ad_oe | output | 1 | Address/data enable |
| ad_in | input | 32 | Address/data lines as received |
| cbe_out | output | 4 | Command / byte-enable drive value |
| cbe_oe | output | 1 | Command / byte-enable enable |
| par_out | output | 1 | Parity drive value |
| par_oe | output | 1 | Parity enable |
| trdy_n | input | 1 | Target ready |
| devsel_n | input | 1 | Target selected |
| stop_n | input | 1 | Target stop request |

## Verification
The bench builds the block with its defaults: AD_W = 32, BEAT_W = 4 and DSEL_CLKS = 6. The 4-bit beat field allows bursts long enough to place a target stop in mid-burst, both with and without data in the stopping phase. A timeout of six clocks lets the bench set device select at exactly the sixth clock after the address phase and at the seventh, which covers the last accepted case and the first abort. A scripted target model also inserts alternating wait states, varies the byte enables per beat down to zero, and holds the bus busy or ungranted to exercise the start condition.

// File: rtl/burst_initiator.sv
module burst_initiator #(
  parameter int AD_W      = 32,
  parameter int BEAT_W    = 4,
  parameter int DSEL_CLKS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AD_W/8-1:0] cmd,
  input  logic [AD_W-1:0]   addr,
  input  logic [BEAT_W-1:0] beats,
  input  logic [AD_W-1:0]   wdata,
  input  logic [AD_W/8-1:0] be,
  output logic              busy,
  output logic [BEAT_W-1:0] beat_cnt,
  output logic              rd_valid,
  output logic [AD_W-1:0]   rd_data,
  output logic              done,
  output logic [1:0]        result,
  output logic              req_n,
  input  logic              gnt_n,
  input  logic              bus_frame_n,
  input  logic              bus_irdy_n,
  output logic              frame_n,
  output logic              irdy_n,
  output logic              ctl_oe,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  input  logic [AD_W-1:0]   ad_in,
  output logic [AD_W/8-1:0] cbe_out,
  output logic              cbe_oe,
  output logic              par_out,
  output logic              par_oe,
  input  logic              trdy_n,
  input  logic              devsel_n,
  input  logic              stop_n
);
  localparam int BE_W  = AD_W / 8;
  localparam int CNT_W = $clog2(DSEL_CLKS + 1);
  localparam logic [1:0] RES_OK     = 2'd0;
  localparam logic [1:0] RES_TSTOP  = 2'd1;
  localparam logic [1:0] RES_TABORT = 2'd2;
  localparam logic [1:0] RES_MABORT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_ARB, S_ADDR, S_TURN, S_DATA, S_DRAIN} state_t;
  state_t st, st_nx;

  logic [BE_W-1:0]   cmd_q;
  logic [AD_W-1:0]   addr_q;
  logic [BEAT_W-1:0] left_q;
  logic [CNT_W-1:0]  dsel_cnt;
  logic              dsel_seen;
  logic              par_q, par_oe_q;

  wire is_read  = ~cmd_q[0];
  wire last     = (left_q == BEAT_W'(1));
  wire xfer     = (st == S_DATA) && !trdy_n && !devsel_n;
  wire tstop    = (st == S_DATA) && !stop_n;
  wire dsel_now = dsel_seen || !devsel_n;
  wire timeout  = (st == S_TURN || st == S_DATA) && !dsel_now && (dsel_cnt == CNT_W'(DSEL_CLKS - 1));
  wire bus_idle = bus_frame_n && bus_irdy_n;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (start) st_nx = S_ARB;
      S_ARB:   if (!gnt_n && bus_idle) st_nx = S_ADDR;
      S_ADDR:  st_nx = is_read ? S_TURN : S_DATA;
      S_TURN:  st_nx = timeout ? S_DRAIN : S_DATA;
      S_DATA: begin
        if (tstop || timeout) st_nx = last ? S_IDLE : S_DRAIN;
        else if (xfer && last) st_nx = S_IDLE;
      end
      S_DRAIN: st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  assign busy    = (st != S_IDLE);
  assign req_n   = (st != S_ARB);
  assign ctl_oe  = (st == S_ADDR) || (st == S_TURN) || (st == S_DATA) || (st == S_DRAIN);
  assign frame_n = !((st == S_ADDR) || (st == S_TURN) || ((st == S_DATA) && !last));
  assign irdy_n  = !((st == S_DATA) || (st == S_DRAIN));
  assign ad_oe   = (st == S_ADDR) || ((st == S_DATA) && !is_read);
  assign ad_out  = (st == S_ADDR) ? addr_q : wdata;
  assign cbe_oe  = ctl_oe;
  assign cbe_out = (st == S_ADDR) ? cmd_q : be;
  assign par_out = par_q;
  assign par_oe  = par_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cmd_q     <= '0;
      addr_q    <= '0;
      left_q    <= '0;
      beat_cnt  <= '0;
      dsel_cnt  <= '0;
      dsel_seen <= 1'b0;
      result    <= RES_OK;
      done      <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      par_q     <= 1'b0;
      par_oe_q  <= 1'b0;
    end else begin
      st       <= st_nx;
      done     <= (st != S_IDLE) && (st_nx == S_IDLE);
      rd_valid <= xfer && is_read;
      if (xfer && is_read) rd_data <= ad_in;
      par_q    <= ^{ad_out, cbe_out};
      par_oe_q <= ad_oe;
      if (st == S_IDLE && start) begin
        cmd_q    <= cmd;
        addr_q   <= addr;
        left_q   <= beats;
        beat_cnt <= '0;
      end
      if (xfer) begin
        beat_cnt <= beat_cnt + BEAT_W'(1);
        left_q   <= left_q - BEAT_W'(1);
      end
      if (st == S_ADDR) begin
        dsel_cnt  <= '0;
        dsel_seen <= 1'b0;
      end else if (st == S_TURN || st == S_DATA) begin
        if (!devsel_n) dsel_seen <= 1'b1;
        else if (!dsel_seen) dsel_cnt <= dsel_cnt + CNT_W'(1);
      end
      if (tstop) result <= devsel_n ? RES_TABORT : RES_TSTOP;
      else if (timeout) result <= RES_MABORT;
      else if (xfer && last) result <= RES_OK;
    end
  end

  AST_WAIT_FOR_BUS: assert property (@(posedge clk) disable iff (!rst_n) $fell(frame_n) |-> $past(!gnt_n && bus_frame_n && bus_irdy_n)); // R2
  AST_READ_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n) ($fell(frame_n) && !cbe_out[0]) |=> (!ad_oe && irdy_n)); // R4
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n) ($fell(frame_n) && cbe_out[0]) |=> (ad_oe && !irdy_n)); // R4
  AST_BEAT_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n) ($past(busy) && beat_cnt != $past(beat_cnt)) |-> $past(!irdy_n && !trdy_n && !devsel_n)); // R5
  AST_WAIT_KEEPS_IRDY: assert property (@(posedge clk) disable iff (!rst_n) (!frame_n && !irdy_n && trdy_n && stop_n && !devsel_n) |=> !irdy_n); // R5
  AST_FRAME_WITH_IRDY: assert property (@(posedge clk) disable iff (!rst_n) $rose(frame_n) |-> !irdy_n); // R12
endmodule

// File: tb/burst_initiator_bench.sv
module burst_initiator_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  cmd = '0;
  logic [31:0] addr = '0;
  logic [3:0]  beats = '0;
  logic [31:0] wdata;
  logic [3:0]  be;
  logic        busy, rd_valid, done, req_n, frame_n, irdy_n, ctl_oe, ad_oe, cbe_oe, par_out, par_oe;
  logic [3:0]  beat_cnt, cbe_out;
  logic [31:0] rd_data, ad_out;
  logic [1:0]  result;
  logic        gnt_n = 1'b0;
  logic        oth_frame_n = 1'b1;
  logic        oth_irdy_n = 1'b1;
  logic        trdy_n = 1'b1;
  logic        devsel_n = 1'b1;
  logic        stop_n = 1'b1;
  logic [31:0] ad_in = '0;
  wire         bus_frame_n = oth_frame_n & frame_n;
  wire         bus_irdy_n  = oth_irdy_n & irdy_n;

  logic [31:0] wmem [16];
  logic [31:0] rmem [16];
  logic [31:0] twmem [16];
  logic [31:0] rcap [16];
  logic [3:0]  bmem [16];
  logic [3:0]  tbe [16];

  assign wdata = wmem[beat_cnt];
  assign be    = bmem[beat_cnt];

  int vectors = 0;
  int errors = 0;
  int t_dsel = 1;
  int t_stop_at = -1;
  bit t_wait = 0;
  bit t_stop_trdy = 0;
  bit t_abort = 0;
  int tcyc = 0;
  int tbeats = 0;
  int rcnt = 0;
  bit in_txn = 0;
  bit prev_frame_n = 1;
  bit stop_data = 0;
  bit turn_ok = 0;
  bit rd_drove = 0;
  logic [31:0] cap_addr = '0;
  logic [3:0]  cap_cmd = '0;
  logic        pexp = 1'b0;
  logic        pexp_oe = 1'b0;

  burst_initiator u_burst_initiator (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr), .beats(beats),
    .wdata(wdata), .be(be), .busy(busy), .beat_cnt(beat_cnt), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .result(result), .req_n(req_n), .gnt_n(gnt_n),
    .bus_frame_n(bus_frame_n), .bus_irdy_n(bus_irdy_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .ctl_oe(ctl_oe), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .cbe_out(cbe_out),
    .cbe_oe(cbe_oe), .par_out(par_out), .par_oe(par_oe), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .stop_n(stop_n)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scripted target, parity monitor and read capture
  always @(negedge clk) begin
    bit dev, rdy, stp;
    if (rst_n) begin
      chk((par_oe == pexp_oe) && (!par_oe || par_out == pexp), "R11 parity", {30'd0, par_oe, par_out}, {30'd0, pexp_oe, pexp});
    end
    pexp    = ^{ad_out, cbe_out};
    pexp_oe = ad_oe;
    if (rd_valid) begin
      rcap[rcnt] = rd_data;
      rcnt++;
    end
    if (!frame_n && prev_frame_n) begin
      in_txn = 1; tcyc = 0; tbeats = 0; rcnt = 0; stop_data = 0; rd_drove = 0;
      cap_addr = ad_out; cap_cmd = cbe_out;
      turn_ok = 1;
    end else if (in_txn) tcyc++;
    prev_frame_n = frame_n;
    if (in_txn && tcyc == 1 && !cap_cmd[0]) turn_ok = !ad_oe && irdy_n;
    if (in_txn && tcyc > 1 && !cap_cmd[0] && ad_oe) rd_drove = 1;
    if (in_txn && tcyc > 0 && frame_n && irdy_n) in_txn = 0;
    dev = in_txn && tcyc > 0 && tcyc >= t_dsel;
    rdy = dev && !irdy_n && (!t_wait || tcyc[0]);
    stp = dev && t_stop_at >= 0 && tbeats >= t_stop_at;
    if (stp) rdy = rdy && t_stop_trdy && !stop_data;
    if (stp && t_abort) begin dev = 0; rdy = 0; end
    devsel_n = !dev;
    trdy_n   = !rdy;
    stop_n   = !stp;
    ad_in    = rmem[tbeats];
    if (!irdy_n && rdy && dev) begin
      twmem[tbeats] = ad_out;
      tbe[tbeats]   = cbe_out;
      tbeats++;
      if (stp) stop_data = 1;
    end
  end

  task automatic setup(input int dsel, input bit wt, input int stop_at, input bit stop_trdy, input bit abrt);
    t_dsel = dsel; t_wait = wt; t_stop_at = stop_at; t_stop_trdy = stop_trdy; t_abort = abrt;
    for (int i = 0; i < 16; i++) begin
      wmem[i] = 32'hA5000000 + 32'(i) * 32'h01010101;
      rmem[i] = 32'h3C000000 ^ (32'(i) << 8) ^ 32'(i * 7);
      bmem[i] = 4'hF;
      twmem[i] = '0;
      rcap[i] = '0;
    end
  endtask

  task automatic launch(input logic [3:0] c, input logic [31:0] a, input logic [3:0] n);
    @(negedge clk);
    start = 1; cmd = c; addr = a; beats = n;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input string req);
    bit seen = 0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk(seen, {req, " done"}, {31'd0, seen}, 32'd1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(req_n && frame_n && irdy_n, "R1 control idle", {29'd0, req_n, frame_n, irdy_n}, 32'd7);
    chk(!ctl_oe && !ad_oe && !cbe_oe && !par_oe && !busy && !done, "R1 enables off",
        {26'd0, ctl_oe, ad_oe, cbe_oe, par_oe, busy, done}, 32'd0);
  endtask

  task automatic t_write_burst;
    setup(1, 0, -1, 0, 0);
    launch(4'b0111, 32'h1000_0040, 4'd4);
    wait_done("R6 write");
    chk(cap_addr == 32'h1000_0040, "R3 address", cap_addr, 32'h1000_0040);
    chk(cap_cmd == 4'b0111, "R3 command", {28'd0, cap_cmd}, 32'h7);
    chk(result == 2'd0, "R6 result", {30'd0, result}, 32'd0);
    chk(beat_cnt == 4'd4, "R6 beats", {28'd0, beat_cnt}, 32'd4);
    for (int i = 0; i < 4; i++) chk(twmem[i] == wmem[i], "R4 write data", twmem[i], wmem[i]);
    chk(frame_n && irdy_n && !ctl_oe, "R6 bus released", {30'd0, frame_n, irdy_n}, 32'd3);
  endtask

  task automatic t_read_burst;
    setup(2, 0, -1, 0, 0);
    launch(4'b0110, 32'h2000_0000, 4'd3);
    wait_done("R4 read");
    chk(turn_ok, "R4 turnaround", {31'd0, turn_ok}, 32'd1);
    chk(!rd_drove, "R4 ad released in read", {31'd0, rd_drove}, 32'd0);
    chk(rcnt == 3, "R4 read count", 32'(rcnt), 32'd3);
    for (int i = 0; i < 3; i++) chk(rcap[i] == rmem[i], "R4 read data", rcap[i], rmem[i]);
    chk(result == 2'd0, "R6 read result", {30'd0, result}, 32'd0);
  endtask

  task automatic t_single_read;
    setup(1, 0, -1, 0, 0);
    launch(4'b1010, 32'h0000_0104, 4'd1);
    wait_done("R6 single");
    chk(cap_cmd == 4'b1010, "R3 config read cmd", {28'd0, cap_cmd}, 32'hA);
    chk(rcnt == 1 && rcap[0] == rmem[0], "R4 single read", rcap[0], rmem[0]);
    chk(beat_cnt == 4'd1, "R6 single beats", {28'd0, beat_cnt}, 32'd1);
  endtask

  task automatic t_wait_states;
    setup(1, 1, -1, 0, 0);
    launch(4'b0011, 32'h0000_0CF8, 4'd4);
    wait_done("R5 wait");
    chk(beat_cnt == 4'd4 && result == 2'd0, "R5 waited beats", {26'd0, result, beat_cnt}, 32'h04);
    for (int i = 0; i < 4; i++) chk(twmem[i] == wmem[i], "R5 data across waits", twmem[i], wmem[i]);
  endtask

  task automatic t_byte_enables;
    setup(1, 0, -1, 0, 0);
    bmem[0] = 4'b0000; bmem[1] = 4'b0101; bmem[2] = 4'b1111;
    launch(4'b0111, 32'h3000_0000, 4'd3);
    wait_done("R7 be");
    for (int i = 0; i < 3; i++) chk(tbe[i] == bmem[i], "R7 byte enables", {28'd0, tbe[i]}, {28'd0, bmem[i]});
  endtask

  task automatic t_master_abort;
    setup(7, 0, -1, 0, 0);
    launch(4'b0111, 32'h4000_0000, 4'd2);
    wait_done("R8 abort");
    chk(result == 2'd3, "R8 master abort", {30'd0, result}, 32'd3);
    chk(beat_cnt == 4'd0, "R8 no beats", {28'd0, beat_cnt}, 32'd0);
    chk(frame_n && irdy_n, "R12 released after abort", {30'd0, frame_n, irdy_n}, 32'd3);
    setup(6, 0, -1, 0, 0);
    launch(4'b0110, 32'h4000_0010, 4'd2);
    wait_done("R8 limit");
    chk(result == 2'd0 && beat_cnt == 4'd2, "R8 sixth clock accepted", {26'd0, result, beat_cnt}, 32'h02);
  endtask

  task automatic t_target_stop;
    setup(1, 0, 2, 1, 0);
    launch(4'b0111, 32'h5000_0000, 4'd5);
    wait_done("R9 stop data");
    chk(result == 2'd1, "R9 stop result", {30'd0, result}, 32'd1);
    chk(beat_cnt == 4'd3, "R9 stop with data", {28'd0, beat_cnt}, 32'd3);
    setup(1, 0, 2, 0, 0);
    launch(4'b0111, 32'h5000_0100, 4'd5);
    wait_done("R9 stop nodata");
    chk(result == 2'd1 && beat_cnt == 4'd2, "R9 stop without data", {26'd0, result, beat_cnt}, 32'h12);
  endtask

  task automatic t_target_abort;
    setup(1, 0, 1, 0, 1);
    launch(4'b0110, 32'h6000_0000, 4'd4);
    wait_done("R10 abort");
    chk(result == 2'd2, "R10 target abort", {30'd0, result}, 32'd2);
    chk(beat_cnt == 4'd1, "R10 beats", {28'd0, beat_cnt}, 32'd1);
  endtask

  task automatic t_arbitration;
    setup(1, 0, -1, 0, 0);
    gnt_n = 1;
    launch(4'b0000, 32'h0, 4'd1);
    repeat (3) @(negedge clk);
    chk(!req_n && frame_n, "R2 wait for grant", {30'd0, req_n, frame_n}, 32'd1);
    gnt_n = 0; oth_frame_n = 0;
    repeat (3) @(negedge clk);
    chk(frame_n, "R2 wait for frame idle", {31'd0, frame_n}, 32'd1);
    oth_frame_n = 1; oth_irdy_n = 0;
    repeat (2) @(negedge clk);
    chk(frame_n, "R2 wait for irdy idle", {31'd0, frame_n}, 32'd1);
    oth_irdy_n = 1;
    @(negedge clk);
    chk(!frame_n && ad_oe && cbe_out == 4'b0000, "R3 addr phase after idle", {30'd0, frame_n, ad_oe}, 32'd1);
    wait_done("R2 arb");
    chk(result == 2'd0, "R2 result", {30'd0, result}, 32'd0);
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    setup(1, 0, -1, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_burst();
    t_single_read();
    t_wait_states();
    t_byte_enables();
    t_master_abort();
    t_target_stop();
    t_target_abort();
    t_arbitration();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule